// File: doc/BRIEF.md
# Cache Tag Flush and Cacheability Controller

This block keeps the configuration of an instruction cache placed in front of a serial flash and a one-time-programmable (OTP) memory. Software reaches it through a simple 32-bit register port. That port holds three settings: the way count, the line length, and a configuration word. The configuration word carries the cacheable flash length and four enable bits. The settings leave the block as plain configuration outputs that the cache datapath uses.

Software starts a flush by writing a command bit. The bit clears itself. The write starts a sequencer that sweeps the tag RAM through a write port, one entry per clock, and clears every valid bit. The number of entries depends on the data RAM size, which is set by a parameter: 8 KB gives 256 entries and 16 KB gives 512. The sequencer has two states, SW_IDLE and SW_RUN, and three transitions:
- A flush request in SW_IDLE moves it to SW_RUN.
- A request while in SW_RUN keeps it in SW_RUN and sends the index back to 0.
- In SW_RUN, reaching the last entry with no request pending returns it to SW_IDLE.

A combinational checker tells the datapath whether a lookup address may be cached. It uses the programmed length, the OTP enable and the busy state.

Top module: `cache_ctl_top`

## Requirements
- R1: After reset, the line-size field reads 0 (8 bytes), the way-count field reads 2 (4-way), the configuration word reads 0, and busy and tag_we are low.
- R2: Fields are readable and writable at these offsets:
  - 0x04: line size in bits [1:0], with codes 0=8 B, 1=16 B, 2=32 B.
  - 0x08: way count in bits [1:0], with codes 0=direct, 1=2-way, 2=4-way.
  - 0x20: the configuration word. Bits [8:0] are the length N. Bit 9 permits debug writes to the cache RAMs, bit 10 enables clock gating, bit 11 caches the OTP, and bit 12 caches the flash when it is remapped. Bits above 12 read 0.
- R3: A write of 1 to bit 0 at offset 0x00 raises busy and tag_we from the next cycle, for exactly ENTRIES cycles. tag_idx runs 0, 1, … ENTRIES-1, with ENTRIES = DATA_KB*32. A write of 0 starts nothing.
- R4: Offset 0x00 always reads 0, including during a sweep.
- R5: A flush write that arrives during a sweep restarts it: the next cycle shows tag_idx 0, followed by a full ENTRIES-cycle sweep.
- R6: A write of the reserved code 3 to the line-size or way-count field is ignored, and the field keeps its previous value.
- R7: When the length N is 0, no address is cacheable, including OTP addresses.
- R8: With N nonzero, an address in [FLASH_BASE, FLASH_BASE+(N+1)*64 KB) is cacheable in the same cycle, and addresses outside it are not.
- R9: With the OTP bit set and N nonzero, addresses in [OTP_BASE, OTP_BASE+OTP_BYTES) are cacheable, and the flash window is capped at 16 MB.
- R10: While busy is high, no address is cacheable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | REG_AW | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lk_addr | input | AW | Lookup address |
| lk_cacheable | output | 1 | Lookup address may be cached |
| tag_we | output | 1 | Tag RAM write (clear valid) strobe |
| tag_idx | output | IDX_W | Tag RAM entry being cleared |
| busy | output | 1 | Flush sweep in progress |
| cfg_assoc | output | 2 | Way-count code |
| cfg_line | output | 2 | Line-size code |
| cfg_ram_wr | output | 1 | Debug write permission for cache RAMs |
| cfg_clk_gate | output | 1 | Clock-gating enable |
| cfg_otp_cache | output | 1 | OTP caching enable |
| cfg_flash_alt | output | 1 | Cache flash when remapped |

## Verification
Register reads and the cacheable decision are combinational, so the bench samples them one time unit after it sets the address. Register writes take effect at the clock edge that samples the strobe, and the bench checks them at the following falling edge. After a flush write, busy rises and tag_idx shows 0 at the falling edge that follows the sampling edge. The bench then checks one index at each falling edge for ENTRIES edges and expects busy low at the next one. Restart is checked the same way, with the count starting again from the second request.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;

    typedef enum logic [1:0] {
        ASSOC_DIRECT = 2'd0,
        ASSOC_TWO    = 2'd1,
        ASSOC_FOUR   = 2'd2,
        ASSOC_RSVD   = 2'd3
    } assoc_e;

    typedef enum logic [1:0] {
        LINE_8B   = 2'd0,
        LINE_16B  = 2'd1,
        LINE_32B  = 2'd2,
        LINE_RSVD = 2'd3
    } line_e;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_e;

    localparam int LEN_W = 9;

    typedef struct packed {
        logic             flash_alt;
        logic             otp_cache;
        logic             clk_gate;
        logic             ram_wr;
        logic [LEN_W-1:0] len;
    } ctrl_word_t;

    localparam int CTRL_W = $bits(ctrl_word_t);

    localparam logic [7:0] OFS_CMD   = 8'h00;
    localparam logic [7:0] OFS_LINE  = 8'h04;
    localparam logic [7:0] OFS_ASSOC = 8'h08;
    localparam logic [7:0] OFS_CTRL  = 8'h20;

endpackage

// File: rtl/cc_regfile.sv
module cc_regfile
    import cache_ctl_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              flush_req,
    output assoc_e            assoc_q,
    output line_e             line_q,
    output ctrl_word_t        ctrl_q
);

    logic hit_cmd, hit_line, hit_assoc, hit_ctrl;

    always_comb begin
        hit_cmd   = (reg_addr == OFS_CMD[REG_AW-1:0]);
        hit_line  = (reg_addr == OFS_LINE[REG_AW-1:0]);
        hit_assoc = (reg_addr == OFS_ASSOC[REG_AW-1:0]);
        hit_ctrl  = (reg_addr == OFS_CTRL[REG_AW-1:0]);
    end

    // Self-clearing command: only the write strobe itself is seen.
    assign flush_req = reg_we && hit_cmd && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            assoc_q <= ASSOC_FOUR;
            line_q  <= LINE_8B;
            ctrl_q  <= '0;
        end else if (reg_we) begin
            if (hit_line && (reg_wdata[1:0] != LINE_RSVD)) begin
                line_q <= line_e'(reg_wdata[1:0]);
            end
            if (hit_assoc && (reg_wdata[1:0] != ASSOC_RSVD)) begin
                assoc_q <= assoc_e'(reg_wdata[1:0]);
            end
            if (hit_ctrl) begin
                ctrl_q <= ctrl_word_t'(reg_wdata[CTRL_W-1:0]);
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_line) begin
            reg_rdata[1:0] = line_q;
        end else if (hit_assoc) begin
            reg_rdata[1:0] = assoc_q;
        end else if (hit_ctrl) begin
            reg_rdata[CTRL_W-1:0] = ctrl_q;
        end
    end

    // R6: a reserved code leaves the field unchanged
    a_r6_assoc_rsvd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_assoc && reg_wdata[1:0] == 2'd3) |=> $stable(assoc_q));
    a_r6_line_rsvd_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_line && reg_wdata[1:0] == 2'd3) |=> $stable(line_q));
    // R2: a configuration write lands on the next cycle
    a_r2_ctrl_written: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && hit_ctrl) |=> (ctrl_q == $past(reg_wdata[CTRL_W-1:0])));

endmodule

// File: rtl/cc_flush_seq.sv
module cc_flush_seq
    import cache_ctl_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_req,
    output logic             busy,
    output logic             tag_we,
    output logic [IDX_W-1:0] tag_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    sweep_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SW_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE: if (flush_req) state_d = SW_RUN;
            SW_RUN:  if (!flush_req && idx_q == LAST) state_d = SW_IDLE;
            default: state_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (flush_req) begin
            idx_q <= '0;
        end else if (state_q == SW_RUN) begin
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end
    end

    always_comb begin
        busy    = 1'b0;
        tag_we  = 1'b0;
        tag_idx = idx_q;
        unique case (state_q)
            SW_IDLE: begin
                busy   = 1'b0;
                tag_we = 1'b0;
            end
            SW_RUN: begin
                busy   = 1'b1;
                tag_we = 1'b1;
            end
            default: begin
                busy   = 1'b0;
                tag_we = 1'b0;
            end
        endcase
    end

    // R3: one entry per cycle, ascending
    a_r3_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush_req && tag_idx != LAST) |=> (busy && tag_idx == $past(tag_idx) + 1'b1));
    // R3: sweep ends after the last entry
    a_r3_sweep_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !flush_req && tag_idx == LAST) |=> !busy);
    // R5: any request (re)starts from entry 0
    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (busy && tag_idx == '0));

endmodule

// File: rtl/cc_cacheable_chk.sv
module cc_cacheable_chk
    import cache_ctl_pkg::*;
#(
    parameter int            AW         = 32,
    parameter logic [AW-1:0] FLASH_BASE = 32'h1000_0000,
    parameter logic [AW-1:0] OTP_BASE   = 32'h0800_0000,
    parameter logic [AW-1:0] OTP_BYTES  = 32'h0001_0000,
    parameter int            UNIT_LG    = 16,
    parameter int            CAP_LG     = 24
) (
    input  logic [LEN_W-1:0] len,
    input  logic             otp_cache,
    input  logic             busy,
    input  logic [AW-1:0]    lk_addr,
    output logic             lk_cacheable
);

    localparam int WIN_W = LEN_W + 1 + UNIT_LG;
    localparam int CMP_W = (WIN_W > AW) ? WIN_W : AW;
    localparam logic [CMP_W-1:0] CAP = CMP_W'(1) << CAP_LG;

    logic [CMP_W-1:0] window, limit, flash_off, otp_off;
    logic             in_flash, in_otp;

    always_comb begin
        window    = CMP_W'({1'b0, len} + 1'b1) << UNIT_LG;
        limit     = (otp_cache && window > CAP) ? CAP : window;
        flash_off = CMP_W'(lk_addr - FLASH_BASE);
        otp_off   = CMP_W'(lk_addr - OTP_BASE);
        in_flash  = (lk_addr >= FLASH_BASE) && (flash_off < limit);
        in_otp    = otp_cache && (lk_addr >= OTP_BASE) && (otp_off < CMP_W'(OTP_BYTES));
        lk_cacheable = !busy && (len != '0) && (in_flash || in_otp);
    end

endmodule

// File: rtl/cache_ctl_top.sv
module cache_ctl_top
    import cache_ctl_pkg::*;
#(
    parameter int            DATA_KB    = 8,
    parameter int            AW         = 32,
    parameter int            REG_AW     = 6,
    parameter logic [AW-1:0] FLASH_BASE = 32'h1000_0000,
    parameter logic [AW-1:0] OTP_BASE   = 32'h0800_0000,
    parameter logic [AW-1:0] OTP_BYTES  = 32'h0001_0000,
    localparam int           ENTRIES    = DATA_KB * 32,
    localparam int           IDX_W      = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [AW-1:0]     lk_addr,
    output logic              lk_cacheable,
    output logic              tag_we,
    output logic [IDX_W-1:0]  tag_idx,
    output logic              busy,
    output logic [1:0]        cfg_assoc,
    output logic [1:0]        cfg_line,
    output logic              cfg_ram_wr,
    output logic              cfg_clk_gate,
    output logic              cfg_otp_cache,
    output logic              cfg_flash_alt
);

    logic       flush_req;
    assoc_e     assoc_q;
    line_e      line_q;
    ctrl_word_t ctrl_q;

    cc_regfile #(.REG_AW(REG_AW), .DW(32)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .flush_req (flush_req),
        .assoc_q   (assoc_q),
        .line_q    (line_q),
        .ctrl_q    (ctrl_q)
    );

    cc_flush_seq #(.ENTRIES(ENTRIES)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_req (flush_req),
        .busy      (busy),
        .tag_we    (tag_we),
        .tag_idx   (tag_idx)
    );

    cc_cacheable_chk #(
        .AW         (AW),
        .FLASH_BASE (FLASH_BASE),
        .OTP_BASE   (OTP_BASE),
        .OTP_BYTES  (OTP_BYTES)
    ) u_chk (
        .len          (ctrl_q.len),
        .otp_cache    (ctrl_q.otp_cache),
        .busy         (busy),
        .lk_addr      (lk_addr),
        .lk_cacheable (lk_cacheable)
    );

    assign cfg_assoc     = assoc_q;
    assign cfg_line      = line_q;
    assign cfg_ram_wr    = ctrl_q.ram_wr;
    assign cfg_clk_gate  = ctrl_q.clk_gate;
    assign cfg_otp_cache = ctrl_q.otp_cache;
    assign cfg_flash_alt = ctrl_q.flash_alt;

    // R10: a running sweep blocks caching
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_cacheable);
    // R7: zero length disables caching
    a_r7_len_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ram_wr == cfg_ram_wr && ctrl_q.len == '0) |-> !lk_cacheable);
    // R4: command offset reads zero
    a_r4_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CMD[REG_AW-1:0]) |-> (reg_rdata == '0));

endmodule

// File: tb/cache_ctl_top_tb_top.sv
module cache_ctl_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_KB    = 8;
    localparam int ENTRIES    = DATA_KB * 32;
    localparam int IDX_W      = $clog2(ENTRIES);
    localparam logic [31:0] FB = 32'h1000_0000;
    localparam logic [31:0] OB = 32'h0800_0000;

    typedef struct packed {
        logic [3:0]  req;
        logic [8:0]  len;
        logic        otp;
        logic [31:0] addr;
        logic        exp;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{4'd7,  9'd0,   1'b0, 32'h1000_0000, 1'b0},  // R7
        '{4'd7,  9'd0,   1'b1, 32'h0800_0000, 1'b0},  // R7
        '{4'd8,  9'd1,   1'b0, 32'h1001_FFFF, 1'b1},  // R8
        '{4'd8,  9'd1,   1'b0, 32'h1002_0000, 1'b0},  // R8
        '{4'd8,  9'd1,   1'b0, 32'h0FFF_FFFF, 1'b0},  // R8
        '{4'd9,  9'd1,   1'b0, 32'h0800_0000, 1'b0},  // R9
        '{4'd9,  9'd1,   1'b1, 32'h0800_FFFF, 1'b1},  // R9
        '{4'd9,  9'd1,   1'b1, 32'h0801_0000, 1'b0},  // R9
        '{4'd8,  9'd511, 1'b0, 32'h11FF_FFFF, 1'b1},  // R8
        '{4'd8,  9'd511, 1'b0, 32'h1200_0000, 1'b0},  // R8
        '{4'd9,  9'd511, 1'b1, 32'h10FF_FFFF, 1'b1},  // R9
        '{4'd9,  9'd511, 1'b1, 32'h1100_0000, 1'b0},  // R9
        '{4'd9,  9'd255, 1'b1, 32'h10FF_FFFF, 1'b1},  // R9
        '{4'd7,  9'd0,   1'b0, 32'h0000_0000, 1'b0}   // R7
    };

    logic             clk, rst_n;
    logic [5:0]       reg_addr;
    logic             reg_we;
    logic [31:0]      reg_wdata, reg_rdata;
    logic [31:0]      lk_addr;
    logic             lk_cacheable, tag_we, busy;
    logic [IDX_W-1:0] tag_idx;
    logic [1:0]       cfg_assoc, cfg_line;
    logic             cfg_ram_wr, cfg_clk_gate, cfg_otp_cache, cfg_flash_alt;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    cache_ctl_top #(.DATA_KB(DATA_KB)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
        .lk_cacheable(lk_cacheable), .tag_we(tag_we), .tag_idx(tag_idx),
        .busy(busy), .cfg_assoc(cfg_assoc), .cfg_line(cfg_line),
        .cfg_ram_wr(cfg_ram_wr), .cfg_clk_gate(cfg_clk_gate),
        .cfg_otp_cache(cfg_otp_cache), .cfg_flash_alt(cfg_flash_alt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_we   = 1'b0;
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic lookup(input logic [31:0] a, output logic c);
        lk_addr = a;
        #1;
        c = lk_cacheable;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic        c;
        rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0; lk_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(6'h04, d); chk("R1 line", d, 32'd0);
        rd(6'h08, d); chk("R1 assoc", d, 32'd2);
        rd(6'h20, d); chk("R1 ctrl", d, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 tag_we", {31'd0, tag_we}, 32'd0);
        chk("R1 cfg_assoc", {30'd0, cfg_assoc}, 32'd2);

        // R2 field access
        wr(6'h04, 32'd2); rd(6'h04, d); chk("R2 line rd", d, 32'd2);
        chk("R2 cfg_line", {30'd0, cfg_line}, 32'd2);
        wr(6'h08, 32'd1); rd(6'h08, d); chk("R2 assoc rd", d, 32'd1);
        wr(6'h20, 32'h0000_1E05); rd(6'h20, d); chk("R2 ctrl rd", d, 32'h1E05);
        chk("R2 enables", {28'd0, cfg_flash_alt, cfg_otp_cache, cfg_clk_gate, cfg_ram_wr}, 32'hF);
        wr(6'h20, 32'hFFFF_FFFF); rd(6'h20, d); chk("R2 ctrl mask", d, 32'h1FFF);
        wr(6'h20, 32'h0000_0200); rd(6'h20, d); chk("R2 ctrl bits", d, 32'h0200);
        chk("R2 ram_wr only", {28'd0, cfg_flash_alt, cfg_otp_cache, cfg_clk_gate, cfg_ram_wr}, 32'h1);

        // R6 reserved codes ignored
        wr(6'h04, 32'd3); rd(6'h04, d); chk("R6 line kept", d, 32'd2);
        chk("R6 cfg_line kept", {30'd0, cfg_line}, 32'd2);
        wr(6'h08, 32'd3); rd(6'h08, d); chk("R6 assoc kept", d, 32'd1);
        wr(6'h04, 32'd1); rd(6'h04, d); chk("R6 legal after rsvd", d, 32'd1);

        // Table walk: R7 R8 R9
        for (int i = 0; i < 14; i++) begin
            wr(6'h20, {20'd0, 1'b0, VECS[i].otp, 2'b00, VECS[i].len});
            lookup(VECS[i].addr, c);
            chk($sformatf("R%0d vec%0d", VECS[i].req, i), {31'd0, c}, {31'd0, VECS[i].exp});
        end

        // R3 sweep, R4 cmd reads zero, R10 busy blocks caching
        wr(6'h20, 32'd1);
        lookup(FB, c); chk("R10 before sweep", {31'd0, c}, 32'd1);
        wr(6'h00, 32'd0);
        chk("R3 zero write no start", {31'd0, busy}, 32'd0);
        wr(6'h00, 32'd1);
        rd(6'h00, d); chk("R4 cmd reads zero", d, 32'd0);
        lookup(FB, c); chk("R10 during sweep", {31'd0, c}, 32'd0);
        for (int i = 0; i < ENTRIES; i++) begin
            chk("R3 sweep step", {busy, tag_we, 30'(tag_idx)}, {2'b11, 30'(i)});
            @(negedge clk);
        end
        chk("R3 sweep done", {30'd0, busy, tag_we}, 32'd0);
        lookup(FB, c); chk("R10 after sweep", {31'd0, c}, 32'd1);

        // R5 restart during sweep
        wr(6'h00, 32'd1);
        repeat (10) @(negedge clk);
        chk("R5 mid sweep idx", 32'(tag_idx), 32'd10);
        wr(6'h00, 32'd1);
        for (int i = 0; i < ENTRIES; i++) begin
            chk("R5 restarted step", {busy, 31'(tag_idx)}, {1'b1, 31'(i)});
            @(negedge clk);
        end
        chk("R5 restarted done", {31'd0, busy}, 32'd0);

        finish_run();
    end

endmodule